// File: doc/BRIEF.md
# SPI status flags and interrupt controller

This block holds the status, the interrupt enables and the forced transfer-end logic of an SPI controller that can run as master or slave. Software sees one status word, one enable word with separate set and clear write strobes, and one interrupt line. On the data side the block tracks the occupancy of the transmit holding register and of the receive data register. On the engine side it grants frame starts, takes frame-complete pulses, and runs the frame-delay and transfer-delay counters through request/done handshakes.

In master mode a frame starts only when a word is waiting, the engine asks for one, and the receive register is empty, so the receiver cannot overrun. After each frame the frame delay runs. If the word carried an end-of-transfer mark, or software has requested an end, the transfer delay follows. In slave mode frames start whenever the engine asks. Missing transmit data and unread receive data are recorded as sticky error flags.

Top module: `spi_stat_irq`

## Requirements
- R1: After reset the status word reads 0x0000_0102 (transmit-ready and master-idle set), the enable word reads 0 and `irq` is 0.
- R2: Status bit 0 (receive-ready) is 1 from the clock edge that takes `eng_done` until the edge that takes `rxd_rd`. Status bit 1 (transmit-ready) is 1 exactly when the holding register is empty: it fills on `txh_wr` and empties when a frame start is granted.
- R3: In master mode `eng_go` is 1 only in a cycle where the sequencer is idle, no end request is pending, `eng_req` is 1, a word is held and the receive register is empty. While the receive register is full, no frame starts.
- R4: In slave mode, an `eng_done` that arrives while the receive register is full and not being read sets status bit 2. The bit stays set until a status write with bit 2 at 1.
- R5: In slave mode, a frame start with the holding register empty sets status bit 3. The bit stays set until a status write with bit 3 at 1. Master mode never sets it.
- R6: The enable word bits 3..0 map to status bits 3..0. A set-strobe write ORs the written bits in, a clear-strobe write removes them, and when both strobes are present the clear wins.
- R7: `irq` equals the OR over bits 3..0 of status AND enable, one clock later.
- R8: In master mode each completed frame raises `fdly_req` until `fdly_done`. If the word was marked with `txh_eot`, `xdly_req` follows until `xdly_done`, and only then does the sequencer go idle.
- R9: A master frame without an end mark and with no end request returns to idle after the frame delay, with no transfer delay.
- R10: A status write with bit 7 at 1 sets the end-request bit 7. Written during a frame, it lets that frame finish and run its frame delay, then forces the transfer delay. The bit clears on the edge that takes `xdly_done`.
- R11: An end request written while the master is idle inside an open transfer runs the transfer delay and then clears. Written with no transfer open, it clears on the next edge with no delay request.
- R12: Status bit 8 (master-idle) is 1 exactly when the holding register is empty and the sequencer is neither shifting nor in a delay.
- R13: Status bits 6..4 and 31..9 and enable bits 31..4 read 0, and writing 1s to them has no effect.
- R14: In slave mode no delay request is raised, and an end request clears on the next edge at which the sequencer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_master | input | 1 | 1 = master mode, 0 = slave mode |
| reg_stat_we | input | 1 | Status write strobe (bits 2,3 clear, bit 7 sets) |
| reg_ien_set_we | input | 1 | Enable set strobe |
| reg_ien_clr_we | input | 1 | Enable clear strobe |
| reg_wdata | input | 32 | Register write data |
| reg_stat | output | 32 | Status word |
| reg_ien | output | 32 | Enable word |
| txh_wr | input | 1 | Software writes the transmit holding register |
| txh_eot | input | 1 | End-of-transfer mark for the word being written |
| rxd_rd | input | 1 | Software reads the receive data register |
| eng_req | input | 1 | Engine is ready to start a frame |
| eng_go | output | 1 | Frame start granted (holding word taken) |
| eng_done | input | 1 | Frame complete, received word delivered |
| fdly_req | output | 1 | Frame delay request |
| fdly_done | input | 1 | Frame delay finished |
| xdly_req | output | 1 | Transfer delay request |
| xdly_done | input | 1 | Transfer delay finished |
| irq | output | 1 | Registered interrupt |

## Verification
The hardest state to reach is an end request that lands while the sequencer is idle but a transfer is still open, that is, after a frame whose word had no end mark. It must then produce a transfer delay without any new frame. A directed sequence first completes an unmarked frame and then writes bit 7, so the request arrives in exactly that window. The same is done with no transfer open, and again during a shifting frame. Random phases in both modes then mix writes, reads, engine pulses and delay completions, and the outputs are compared every cycle against a bench model.

// File: rtl/spi_si_pkg.sv
`timescale 1ns/1ps
package spi_si_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_FDLY, ST_XDLY} seq_st_t;
  localparam int unsigned NSRC    = 4;
  localparam int unsigned B_RXRDY = 0;
  localparam int unsigned B_TXRDY = 1;
  localparam int unsigned B_RXOV  = 2;
  localparam int unsigned B_TXUR  = 3;
  localparam int unsigned B_ENDX  = 7;
  localparam int unsigned B_MIDLE = 8;
endpackage

// File: rtl/spi_si_flags.sv
`timescale 1ns/1ps
module spi_si_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_master,
  input  logic txh_wr,
  input  logic txh_eot,
  input  logic rxd_rd,
  input  logic go,
  input  logic done,
  input  logic clr_ov,
  input  logic clr_ur,
  output logic tx_full,
  output logic tx_eot,
  output logic rx_full,
  output logic rx_ov,
  output logic tx_ur
);
  logic tx_full_n, tx_eot_n, rx_full_n, rx_ov_n, tx_ur_n;

  always_comb begin
    tx_full_n = txh_wr | (tx_full & ~go);
    tx_eot_n  = txh_wr ? txh_eot : tx_eot;
    rx_full_n = done | (rx_full & ~rxd_rd);
    rx_ov_n   = (rx_ov & ~clr_ov) | (~cfg_master & done & rx_full & ~rxd_rd);
    tx_ur_n   = (tx_ur & ~clr_ur) | (~cfg_master & go & ~tx_full);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_full <= 1'b0;
      tx_eot  <= 1'b0;
      rx_full <= 1'b0;
      rx_ov   <= 1'b0;
      tx_ur   <= 1'b0;
    end else begin
      tx_full <= tx_full_n;
      tx_eot  <= tx_eot_n;
      rx_full <= rx_full_n;
      rx_ov   <= rx_ov_n;
      tx_ur   <= tx_ur_n;
    end
  end

  // R3: the sequencer never grants a master frame into a full receiver
  a_r3_no_go_rx_full: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && go |-> !rx_full);
  // R4: overrun flag is sticky until cleared
  a_r4_ov_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ov && !clr_ov |=> rx_ov);
  // R5: no underrun recorded in master mode
  a_r5_no_ur_master: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master |=> !$rose(tx_ur));
endmodule

// File: rtl/spi_si_seq.sv
`timescale 1ns/1ps
module spi_si_seq
  import spi_si_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_master,
  input  logic eng_req,
  input  logic eng_done,
  input  logic tx_full,
  input  logic tx_eot,
  input  logic rx_full,
  input  logic endx_wr,
  input  logic fdly_done,
  input  logic xdly_done,
  output logic go,
  output logic fdly_req,
  output logic xdly_req,
  output logic endx,
  output logic mst_idle
);
  seq_st_t st, st_n;
  logic endx_n, xact, xact_n, ecur, ecur_n;

  always_comb begin
    st_n   = st;
    endx_n = endx;
    xact_n = xact;
    ecur_n = ecur;
    go     = 1'b0;
    if (cfg_master) begin
      unique case (st)
        ST_IDLE: begin
          if (endx) begin
            if (xact) st_n = ST_XDLY;
            else      endx_n = 1'b0;
          end else if (eng_req && tx_full && !rx_full) begin
            go     = 1'b1;
            st_n   = ST_SHIFT;
            xact_n = 1'b1;
            ecur_n = tx_eot;
          end
        end
        ST_SHIFT: if (eng_done) st_n = ST_FDLY;
        ST_FDLY:  if (fdly_done) st_n = (ecur || endx) ? ST_XDLY : ST_IDLE;
        ST_XDLY: begin
          if (xdly_done) begin
            st_n   = ST_IDLE;
            xact_n = 1'b0;
            endx_n = 1'b0;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end else begin
      xact_n = 1'b0;
      ecur_n = 1'b0;
      unique case (st)
        ST_IDLE: begin
          endx_n = 1'b0;
          if (eng_req) begin
            go   = 1'b1;
            st_n = ST_SHIFT;
          end
        end
        ST_SHIFT: if (eng_done) st_n = ST_IDLE;
        default:  st_n = ST_IDLE;
      endcase
    end
    if (endx_wr) endx_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      endx <= 1'b0;
      xact <= 1'b0;
      ecur <= 1'b0;
    end else begin
      st   <= st_n;
      endx <= endx_n;
      xact <= xact_n;
      ecur <= ecur_n;
    end
  end

  assign fdly_req = cfg_master && (st == ST_FDLY);
  assign xdly_req = cfg_master && (st == ST_XDLY);
  assign mst_idle = !tx_full && (st == ST_IDLE);

  // R12: a granted frame makes the master busy on the next cycle
  a_r12_busy_after_go: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !mst_idle);
  // R8: transfer delay is entered only after a frame delay or on an end request
  a_r8_xdly_entry: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && $rose(xdly_req) |-> $past(fdly_req) || $past(endx));
  // R10: inside an open transfer the end request drops only with the transfer delay done
  a_r10_endx_release: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master && $past(cfg_master) && $fell(endx) && $past(xact) |-> $past(xdly_done));
endmodule

// File: rtl/spi_si_irq.sv
`timescale 1ns/1ps
module spi_si_irq #(
  parameter int unsigned NSRC = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_we,
  input  logic            clr_we,
  input  logic [NSRC-1:0] wmask,
  input  logic [NSRC-1:0] flags,
  output logic [NSRC-1:0] ien,
  output logic            irq
);
  logic [NSRC-1:0] ien_n, set_m, clr_m;
  logic            irq_n;

  always_comb begin
    set_m = set_we ? wmask : '0;
    clr_m = clr_we ? wmask : '0;
    ien_n = (ien | set_m) & ~clr_m;
    irq_n = |(flags & ien);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien <= '0;
      irq <= 1'b0;
    end else begin
      ien <= ien_n;
      irq <= irq_n;
    end
  end

  // R6: a set-only write leaves every written enable bit at 1
  a_r6_set_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    set_we && !clr_we |=> (ien & $past(wmask)) == $past(wmask));
  // R7: with all enables off the line stays quiet next cycle
  a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0) |=> !irq);
endmodule

// File: rtl/spi_stat_irq.sv
`timescale 1ns/1ps
module spi_stat_irq
  import spi_si_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_master,
  input  logic             reg_stat_we,
  input  logic             reg_ien_set_we,
  input  logic             reg_ien_clr_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_stat,
  output logic [REG_W-1:0] reg_ien,
  input  logic             txh_wr,
  input  logic             txh_eot,
  input  logic             rxd_rd,
  input  logic             eng_req,
  output logic             eng_go,
  input  logic             eng_done,
  output logic             fdly_req,
  input  logic             fdly_done,
  output logic             xdly_req,
  input  logic             xdly_done,
  output logic             irq
);
  logic tx_full, tx_eot, rx_full, rx_ov, tx_ur;
  logic endx, mst_idle, go;
  logic [NSRC-1:0] flags, ien;

  spi_si_flags u_flags (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
    .txh_wr(txh_wr), .txh_eot(txh_eot), .rxd_rd(rxd_rd),
    .go(go), .done(eng_done),
    .clr_ov(reg_stat_we & reg_wdata[B_RXOV]),
    .clr_ur(reg_stat_we & reg_wdata[B_TXUR]),
    .tx_full(tx_full), .tx_eot(tx_eot), .rx_full(rx_full),
    .rx_ov(rx_ov), .tx_ur(tx_ur)
  );

  spi_si_seq u_seq (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
    .eng_req(eng_req), .eng_done(eng_done),
    .tx_full(tx_full), .tx_eot(tx_eot), .rx_full(rx_full),
    .endx_wr(reg_stat_we & reg_wdata[B_ENDX]),
    .fdly_done(fdly_done), .xdly_done(xdly_done),
    .go(go), .fdly_req(fdly_req), .xdly_req(xdly_req),
    .endx(endx), .mst_idle(mst_idle)
  );

  always_comb begin
    flags          = '0;
    flags[B_RXRDY] = rx_full;
    flags[B_TXRDY] = ~tx_full;
    flags[B_RXOV]  = rx_ov;
    flags[B_TXUR]  = tx_ur;
  end

  spi_si_irq #(.NSRC(NSRC)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_we(reg_ien_set_we), .clr_we(reg_ien_clr_we),
    .wmask(reg_wdata[NSRC-1:0]), .flags(flags),
    .ien(ien), .irq(irq)
  );

  always_comb begin
    reg_stat              = '0;
    reg_stat[NSRC-1:0]    = flags;
    reg_stat[B_ENDX]      = endx;
    reg_stat[B_MIDLE]     = mst_idle;
    reg_ien               = '0;
    reg_ien[NSRC-1:0]     = ien;
  end

  assign eng_go = go;
endmodule

// File: tb/spi_stat_irq_tb.sv
`timescale 1ns/1ps
module spi_stat_irq_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, cfg_master, reg_stat_we, reg_ien_set_we, reg_ien_clr_we;
  logic [31:0] reg_wdata, reg_stat, reg_ien;
  logic txh_wr, txh_eot, rxd_rd, eng_req, eng_go, eng_done;
  logic fdly_req, fdly_done, xdly_req, xdly_done, irq;

  spi_stat_irq u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
    .reg_stat_we(reg_stat_we), .reg_ien_set_we(reg_ien_set_we),
    .reg_ien_clr_we(reg_ien_clr_we), .reg_wdata(reg_wdata),
    .reg_stat(reg_stat), .reg_ien(reg_ien),
    .txh_wr(txh_wr), .txh_eot(txh_eot), .rxd_rd(rxd_rd),
    .eng_req(eng_req), .eng_go(eng_go), .eng_done(eng_done),
    .fdly_req(fdly_req), .fdly_done(fdly_done),
    .xdly_req(xdly_req), .xdly_done(xdly_done), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;

  // bench model (state codes: 0 idle, 1 shifting, 2 frame delay, 3 transfer delay)
  bit m_txf, m_eot, m_rxf, m_ov, m_ur, m_ex, m_xa, m_ecur, m_irq;
  bit [1:0] m_st;
  bit [3:0] m_ien;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit exp_go();
    if (cfg_master) return (m_st == 2'd0) && !m_ex && eng_req && m_txf && !m_rxf;
    return (m_st == 2'd0) && eng_req;
  endfunction

  function automatic logic [31:0] exp_stat();
    logic [31:0] s;
    s = '0;
    s[0] = m_rxf; s[1] = !m_txf; s[2] = m_ov; s[3] = m_ur;
    s[7] = m_ex;  s[8] = !m_txf && (m_st == 2'd0);
    return s;
  endfunction

  function automatic string stat_tag(logic [31:0] d);
    if (d[1:0] != 0) return "R2 ready bits";
    if (d[2]) return "R4 overrun";
    if (d[3]) return "R5 underrun";
    if (d[7]) return "R10 end request";
    if (d[8]) return "R12 master idle";
    return "R13 reserved status";
  endfunction

  task automatic compare_all();
    logic [31:0] es;
    es = exp_stat();
    chk("R3 eng_go", {31'b0, eng_go}, {31'b0, exp_go()});
    chk("R8 fdly_req", {31'b0, fdly_req}, {31'b0, cfg_master && m_st == 2'd2});
    chk("R8 xdly_req", {31'b0, xdly_req}, {31'b0, cfg_master && m_st == 2'd3});
    chk(stat_tag(reg_stat ^ es), reg_stat, es);
    chk("R6 enables", reg_ien, {28'b0, m_ien});
    chk("R7 irq", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic model_update();
    bit go, ex_n, xa_n, ecur_n;
    bit [1:0] st_n;
    bit [3:0] fl, smask, cmask;
    go = exp_go();
    fl = {m_ur, m_ov, !m_txf, m_rxf};
    st_n = m_st; ex_n = m_ex; xa_n = m_xa; ecur_n = m_ecur;
    if (cfg_master) begin
      case (m_st)
        2'd0: if (m_ex) begin if (m_xa) st_n = 2'd3; else ex_n = 0; end
              else if (go) begin st_n = 2'd1; xa_n = 1; ecur_n = m_eot; end
        2'd1: if (eng_done) st_n = 2'd2;
        2'd2: if (fdly_done) st_n = (m_ecur || m_ex) ? 2'd3 : 2'd0;
        default: if (xdly_done) begin st_n = 2'd0; xa_n = 0; ex_n = 0; end
      endcase
    end else begin
      xa_n = 0; ecur_n = 0;
      case (m_st)
        2'd0: begin ex_n = 0; if (go) st_n = 2'd1; end
        2'd1: if (eng_done) st_n = 2'd0;
        default: st_n = 2'd0;
      endcase
    end
    if (reg_stat_we && reg_wdata[7]) ex_n = 1;
    m_irq = |(fl & m_ien);
    smask = reg_ien_set_we ? reg_wdata[3:0] : 4'b0;
    cmask = reg_ien_clr_we ? reg_wdata[3:0] : 4'b0;
    m_ien = (m_ien | smask) & ~cmask;
    m_ov  = (m_ov & !(reg_stat_we && reg_wdata[2])) | (!cfg_master & eng_done & m_rxf & !rxd_rd);
    m_ur  = (m_ur & !(reg_stat_we && reg_wdata[3])) | (!cfg_master & go & !m_txf);
    m_rxf = eng_done | (m_rxf & !rxd_rd);
    m_eot = txh_wr ? txh_eot : m_eot;
    m_txf = txh_wr | (m_txf & !go);
    m_st = st_n; m_ex = ex_n; m_xa = xa_n; m_ecur = ecur_n;
  endtask

  task automatic clear_inputs();
    reg_stat_we = 0; reg_ien_set_we = 0; reg_ien_clr_we = 0; reg_wdata = '0;
    txh_wr = 0; txh_eot = 0; rxd_rd = 0; eng_req = 0; eng_done = 0;
    fdly_done = 0; xdly_done = 0;
  endtask

  task automatic step();
    #1 compare_all();
    @(negedge clk);
    model_update();
    clear_inputs();
  endtask

  task automatic drain();
    for (int i = 0; i < 300; i++) begin
      if (m_st == 2'd0 && !m_xa && !m_ex) break;
      eng_done = (m_st == 2'd1); fdly_done = (m_st == 2'd2);
      xdly_done = (m_st == 2'd3); rxd_rd = 1;
      if (i % 8 == 0) begin reg_stat_we = 1; reg_wdata = 32'h80; end
      step();
    end
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired (all requirements) act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    clear_inputs();
    cfg_master = 1; rst_n = 0;
    m_txf = 0; m_eot = 0; m_rxf = 0; m_ov = 0; m_ur = 0; m_ex = 0;
    m_xa = 0; m_ecur = 0; m_irq = 0; m_st = 0; m_ien = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #0.5;
    chk("R1 reset status", reg_stat, 32'h0000_0102);
    chk("R1 reset enables", reg_ien, 32'h0);
    chk("R1 reset irq", {31'b0, irq}, 32'h0);
    step();

    // unmarked master frame: frame delay only
    txh_wr = 1; step();
    eng_req = 1; step();
    eng_done = 1; step();
    rxd_rd = 1; step();
    fdly_done = 1; step();
    #0.5 chk("R9 no transfer delay", {31'b0, xdly_req}, 32'h0);
    chk("R9 master idle", {31'b0, reg_stat[8]}, 32'h1);

    // end request inside an open transfer while idle
    reg_stat_we = 1; reg_wdata = 32'h80; step();
    step();
    #0.5 chk("R11 transfer delay forced", {31'b0, xdly_req}, 32'h1);
    chk("R11 end bit held", {31'b0, reg_stat[7]}, 32'h1);
    xdly_done = 1; step();
    #0.5 chk("R11 end bit cleared", {31'b0, reg_stat[7]}, 32'h0);

    // end request with no transfer open
    reg_stat_we = 1; reg_wdata = 32'h80; step();
    #0.5 chk("R11 end bit visible", {31'b0, reg_stat[7]}, 32'h1);
    step();
    #0.5 chk("R11 cleared without delay", {31'b0, reg_stat[7]}, 32'h0);
    chk("R11 no delay request", {31'b0, xdly_req}, 32'h0);

    // end request during a shifting frame
    txh_wr = 1; step();
    eng_req = 1; step();
    reg_stat_we = 1; reg_wdata = 32'h80; step();
    eng_done = 1; step();
    #0.5 chk("R10 frame delay first", {31'b0, fdly_req}, 32'h1);
    fdly_done = 1; rxd_rd = 1; step();
    #0.5 chk("R10 transfer delay after", {31'b0, xdly_req}, 32'h1);
    xdly_done = 1; step();
    #0.5 chk("R10 end bit cleared", {31'b0, reg_stat[7]}, 32'h0);
    chk("R10 idle after end", {31'b0, reg_stat[8]}, 32'h1);

    // marked frame: both delays
    txh_wr = 1; txh_eot = 1; step();
    eng_req = 1; step();
    eng_done = 1; step();
    fdly_done = 1; rxd_rd = 1; step();
    #0.5 chk("R8 marked word adds transfer delay", {31'b0, xdly_req}, 32'h1);
    xdly_done = 1; step();

    // master stalls on a full receiver
    txh_wr = 1; step();
    eng_req = 1; step();
    eng_done = 1; step();
    fdly_done = 1; step();
    txh_wr = 1; step();
    for (int i = 0; i < 4; i++) begin
      eng_req = 1;
      #0.5 chk("R3 stalled while receiver full", {31'b0, eng_go}, 32'h0);
      step();
    end
    eng_req = 1; rxd_rd = 1; step();
    eng_req = 1;
    #0.5 chk("R3 resumes after read", {31'b0, eng_go}, 32'h1);
    step();
    eng_done = 1; step();
    fdly_done = 1; rxd_rd = 1; step();

    // enables and interrupt latency
    reg_ien_set_we = 1; reg_wdata = 32'hFFFF_FFFF; step();
    #0.5 chk("R13 enable upper bits", reg_ien, 32'hF);
    reg_ien_set_we = 1; reg_ien_clr_we = 1; reg_wdata = 32'h3; step();
    #0.5 chk("R6 clear wins", reg_ien, 32'hC);
    step();
    reg_ien_set_we = 1; reg_wdata = 32'h2; step();
    #0.5 chk("R7 not yet", {31'b0, irq}, 32'h0);
    step();
    #0.5 chk("R7 one cycle later", {31'b0, irq}, 32'h1);
    reg_ien_clr_we = 1; reg_wdata = 32'hF; step();
    reg_stat_we = 1; reg_wdata = 32'hFFFF_FF73; step();
    #0.5 chk("R13 reserved status", reg_stat & 32'hFFFF_FE70, 32'h0);
    drain();

    // slave mode
    cfg_master = 0;
    eng_req = 1; step();
    #0.5 chk("R5 underrun set", {31'b0, reg_stat[3]}, 32'h1);
    chk("R14 no delay in slave", {31'b0, fdly_req}, 32'h0);
    eng_done = 1; step();
    eng_req = 1; step();
    eng_done = 1; step();
    #0.5 chk("R4 overrun set", {31'b0, reg_stat[2]}, 32'h1);
    reg_stat_we = 1; reg_wdata = 32'hC; rxd_rd = 1; step();
    #0.5 chk("R4 overrun cleared", {31'b0, reg_stat[2]}, 32'h0);
    chk("R5 underrun cleared", {31'b0, reg_stat[3]}, 32'h0);
    reg_stat_we = 1; reg_wdata = 32'h80; step();
    #0.5 chk("R14 end bit set", {31'b0, reg_stat[7]}, 32'h1);
    step();
    #0.5 chk("R14 end bit cleared at idle", {31'b0, reg_stat[7]}, 32'h0);

    // random master phase
    cfg_master = 1;
    for (int i = 0; i < 3000; i++) begin
      eng_req = $urandom % 2; txh_wr = ($urandom % 4) == 0;
      txh_eot = ($urandom % 3) == 0; rxd_rd = ($urandom % 3) == 0;
      eng_done = (m_st == 2'd1) && (($urandom % 3) == 0);
      fdly_done = (m_st == 2'd2) && ($urandom % 2);
      xdly_done = (m_st == 2'd3) && ($urandom % 2);
      reg_stat_we = ($urandom % 12) == 0; reg_wdata = $urandom;
      reg_ien_set_we = ($urandom % 6) == 0; reg_ien_clr_we = ($urandom % 8) == 0;
      step();
    end
    drain();

    // random slave phase
    cfg_master = 0;
    for (int i = 0; i < 3000; i++) begin
      eng_req = (m_st == 2'd0) && (($urandom % 3) == 0);
      eng_done = (m_st == 2'd1) && ($urandom % 2);
      txh_wr = ($urandom % 4) == 0; txh_eot = $urandom % 2;
      rxd_rd = ($urandom % 5) == 0;
      reg_stat_we = ($urandom % 10) == 0; reg_wdata = $urandom;
      reg_ien_set_we = ($urandom % 6) == 0; reg_ien_clr_we = ($urandom % 8) == 0;
      step();
    end

    summary();
    $finish;
  end
endmodule